// File: doc/BRIEF.md
# Switch-Programmed Single-Cycle Datapath

This block is an 8-bit processor datapath that completes one instruction on every rising clock edge. There is no fetch stage and no program counter. A 10-bit instruction word arrives on an input port, is decoded combinationally, and steers the register file, the ALU, the data memory and an output holding register. Whatever the word selects as the result is committed at the next edge. An outer sequencer or an operator presents one word per cycle.

The register file has four 8-bit registers with two read ports. The first operand register is usually both a source and the destination. The ALU always computes six condition flags from both the sum and the difference of its operands, whatever opcode is selected. A 128-word data memory is read asynchronously and is never cleared. Stores look at the top bit of the address register. A store to an address of 128 or more updates an output holding register instead of the memory, which gives the program a memory-mapped output.

Top module: `sw_cpu`

## Requirements
- R1: Reset clears R0 to R3 and the output register to zero, and leaves the data memory contents unchanged.
- R2: The instruction fields are: bit 9 register write enable, bits 8:7 first operand rA, bits 6:5 second operand rB, bits 4:3 ALU opcode, bit 2 immediate select, bits 1:0 result source (00 ALU, 01 rB, 10 immediate, 11 memory read data).
- R3: ALU opcodes 00 add, 01 subtract (rA minus rB), 10 multiply keeping the low 8 bits, 11 bitwise AND, all modulo 256. With write enable and source 00, rA takes the ALU result at the next edge.
- R4: With write enable and source 01, rA takes the value of rB.
- R5: With write enable and source 10, rA takes 0x01 when bit 2 is 0 and 0xFF when bit 2 is 1.
- R6: With write enable and source 11, rA takes the memory word addressed by the low 7 bits of rB, including when rB is 128 or above.
- R7: With write enable clear and source 11, and rB below 128, memory word rB takes rA. No register and not the output register changes.
- R8: With write enable clear and source 11, and rB 128 or above, the output register takes rA and the memory word at rB's low 7 bits is left unchanged.
- R9: The output register keeps its value across every instruction that is not a store at an address of 128 or above.
- R10: flags bit 0 is the unsigned carry of rA+rB, bit 1 the unsigned borrow of rA-rB, bit 2 the signed overflow of rA+rB, bit 3 the signed overflow of rA-rB, bit 4 the top bit of the ALU result, and bit 5 is set when the ALU result is zero. All of them are valid for any opcode.
- R11: An instruction with write enable clear and source other than 11 changes no register, no memory word and not the output register.
- R12: port_a shows register rA and result_bus shows the selected result combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of registers and output register |
| instr | input | 10 | Instruction word for the current cycle |
| result_bus | output | 8 | Value selected by the result-source field |
| out_val | output | 8 | Memory-mapped output holding register |
| port_a | output | 8 | Register file read port for rA |
| flags | output | 6 | ALU condition flags |

## Verification
The datapath runs a short program through a scoreboard. The program builds values from the two immediates alone, and a reference model predicts the result bus, port A, the flags and the output register for every instruction. The arithmetic patterns include a doubling chain up to 0x80, a wrap of 0xFF+1, a small subtraction that borrows, and a subtraction that underflows from 0x80. Together they separate the carry, borrow and both overflow flags from one another and from zero and sign. Stores go once to the low half of the address space and once to the high half at an address that aliases a written memory word. A load through that same address then shows whether address decoding kept the memory intact. A reset in the middle of the program, followed by a load, separates register clearing from memory retention.

// File: rtl/sw_cpu_pkg.sv
package sw_cpu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_AND = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_ALU = 2'b00,
        SRC_RB  = 2'b01,
        SRC_IMM = 2'b10,
        SRC_MEM = 2'b11
    } res_src_e;

    // instruction word layout, msb first
    typedef struct packed {
        logic     wr_en;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        alu_op_e  op;
        logic     imm_neg;
        res_src_e src;
    } instr_t;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf_sub;
        logic ovf_add;
        logic borrow;
        logic carry;
    } flags_t;

endpackage

// File: rtl/sw_cpu_alu.sv
module sw_cpu_alu
    import sw_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output flags_t       fl
);
    logic [W-1:0] sum, dif;
    logic a7, b7, s7, d7;

    always_comb begin
        sum = a + b;
        dif = a - b;
        unique case (op)
            OP_ADD: y = sum;
            OP_SUB: y = dif;
            OP_MUL: y = a * b;
            default: y = a & b;
        endcase
        a7 = a[W-1];
        b7 = b[W-1];
        s7 = sum[W-1];
        d7 = dif[W-1];
        // flags come from operand and result sign bits only
        fl.carry   = (a7 & b7) | (a7 & ~s7) | (b7 & ~s7);
        fl.borrow  = (~a7 & b7) | (b7 & d7) | (~a7 & d7);
        fl.ovf_add = (~a7 & ~b7 & s7) | (a7 & b7 & ~s7);
        fl.ovf_sub = (a7 & ~b7 & ~d7) | (~a7 & b7 & d7);
        fl.neg     = y[W-1];
        fl.zero    = ~|y;
    end
endmodule

// File: rtl/sw_cpu_regfile.sv
module sw_cpu_regfile #(
    parameter int W     = 8,
    parameter int NREG  = 4,
    localparam int SW_  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [SW_-1:0] wsel,
    input  logic [W-1:0]   wdata,
    input  logic [SW_-1:0] sel_a,
    input  logic [SW_-1:0] sel_b,
    output logic [W-1:0]   q_a,
    output logic [W-1:0]   q_b
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] r;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) rf_d.r[wsel] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign q_a = rf_q.r[sel_a];
    assign q_b = rf_q.r[sel_b];

    AST_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> rf_q.r[$past(wsel)] == $past(wdata)); // R3
    AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(rf_q)); // R11
    AST_RF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rf_q == '0); // R1
endmodule

// File: rtl/sw_cpu_dmem.sv
module sw_cpu_dmem #(
    parameter int W  = 8,
    parameter int AW = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // no reset: contents survive it
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sw_cpu.sv
module sw_cpu
    import sw_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MEM_AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        instr,
    output logic [DATA_W-1:0] result_bus,
    output logic [DATA_W-1:0] out_val,
    output logic [DATA_W-1:0] port_a,
    output logic [5:0]        flags
);
    localparam int NREG = 4;

    instr_t ins;
    assign ins = instr_t'(instr);

    logic [DATA_W-1:0] rd_a, rd_b, alu_y, mem_rd, imm_val;
    flags_t            alu_fl;
    logic              store_req, io_hit, mem_we, io_we;

    sw_cpu_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .we(ins.wr_en), .wsel(ins.sel_a),
        .wdata(result_bus), .sel_a(ins.sel_a), .sel_b(ins.sel_b),
        .q_a(rd_a), .q_b(rd_b)
    );

    sw_cpu_alu #(.W(DATA_W)) u_alu (
        .a(rd_a), .b(rd_b), .op(ins.op), .y(alu_y), .fl(alu_fl)
    );

    sw_cpu_dmem #(.W(DATA_W), .AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .addr(rd_b[MEM_AW-1:0]),
        .wdata(rd_a), .rdata(mem_rd)
    );

    // address decode: any bit above the memory range selects the output
    always_comb begin
        store_req = !ins.wr_en && (ins.src == SRC_MEM);
        io_hit    = |rd_b[DATA_W-1:MEM_AW];
        mem_we    = store_req && !io_hit;
        io_we     = store_req && io_hit;
        imm_val   = ins.imm_neg ? '1 : DATA_W'(1);
        unique case (ins.src)
            SRC_ALU: result_bus = alu_y;
            SRC_RB:  result_bus = rd_b;
            SRC_IMM: result_bus = imm_val;
            default: result_bus = mem_rd;
        endcase
    end

    typedef struct packed {
        logic [DATA_W-1:0] outr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_we) st_d.outr = rd_a;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_val = st_q.outr;
    assign port_a  = rd_a;
    assign flags   = alu_fl;

    // independent 9-bit reference for the carry flag
    logic [DATA_W:0] chk_sum;
    assign chk_sum = {1'b0, rd_a} + {1'b0, rd_b};

    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        io_we |=> out_val == $past(rd_a)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !io_we |=> $stable(out_val)); // R9
    AST_MEM_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> u_mem.mem_q[$past(rd_b[MEM_AW-1:0])] == $past(rd_a)); // R7
    AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (rst)
        alu_fl.carry == chk_sum[DATA_W]); // R10
    AST_NO_STORE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        ins.wr_en |-> !mem_we && !io_we); // R11
endmodule

// File: tb/sim_sw_cpu.sv
`timescale 1ns/1ps
module sim_sw_cpu;
    logic       clk = 0;
    logic       rst = 1;
    logic [9:0] instr = '0;
    logic [7:0] result_bus, out_val, port_a;
    logic [5:0] flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sw_cpu u0 (
        .clk(clk), .rst(rst), .instr(instr), .result_bus(result_bus),
        .out_val(out_val), .port_a(port_a), .flags(flags)
    );

    typedef struct {
        logic [7:0] res;
        logic [7:0] rda;
        logic [7:0] outv;
        logic [5:0] fl;
        string      tag;
    } item_t;

    item_t q[$];

    logic [7:0] m_reg [4];
    logic [7:0] m_mem [128];
    logic [7:0] m_out;

    function automatic void model_alu(input logic [7:0] a, input logic [7:0] b,
                                      input int op, output logic [7:0] y,
                                      output logic [5:0] f);
        logic [8:0] s9, d9;
        logic [7:0] s, d;
        s9 = {1'b0, a} + {1'b0, b};
        d9 = {1'b0, a} - {1'b0, b};
        s = s9[7:0];
        d = d9[7:0];
        case (op)
            0: y = s;
            1: y = d;
            2: y = 8'((16'(a) * 16'(b)) & 16'hFF);
            default: y = a & b;
        endcase
        f[0] = s9[8];
        f[1] = d9[8];
        f[2] = (a[7] == b[7]) && (s[7] != a[7]);
        f[3] = (a[7] != b[7]) && (d[7] != a[7]);
        f[4] = y[7];
        f[5] = (y == 8'h00);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        instr = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
        m_out = 8'h00;
    endtask

    // driver: applies one instruction and queues the expected outputs
    task automatic ins(input bit we, input int ra, input int rb, input int op,
                       input bit imm, input int src, input string tag);
        item_t it;
        logic [7:0] a, b, y, r;
        logic [5:0] f;
        @(negedge clk);
        instr = {we, 2'(ra), 2'(rb), 2'(op), imm, 2'(src)};
        a = m_reg[ra];
        b = m_reg[rb];
        model_alu(a, b, op, y, f);
        case (src)
            0: r = y;
            1: r = b;
            2: r = imm ? 8'hFF : 8'h01;
            default: r = m_mem[b[6:0]];
        endcase
        it.res = r; it.rda = a; it.outv = m_out; it.fl = f; it.tag = tag;
        q.push_back(it);
        if (we) m_reg[ra] = r;
        else if (src == 3) begin
            if (b < 8'd128) m_mem[b[6:0]] = a;
            else            m_out = a;
        end
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compares combinational outputs mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                cmp(it.tag, "result_bus", result_bus, it.res);
                cmp(it.tag, "port_a", port_a, it.rda);
                cmp(it.tag, "out_val", out_val, it.outv);
                cmp(it.tag, "flags", {2'b00, flags}, {2'b00, it.fl});
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: all registers and output start at zero
        for (int k = 0; k < 4; k++) ins(0, k, 0, 0, 0, 0, "R1");
        ins(1, 0, 0, 0, 0, 2, "R5");          // R0 = +1
        ins(1, 1, 0, 0, 1, 2, "R5");          // R1 = -1
        ins(1, 2, 0, 0, 0, 1, "R4 R2");       // R2 = R0
        ins(1, 3, 2, 0, 0, 0, "R3");          // R3 = 1
        ins(1, 3, 3, 0, 0, 0, "R3");          // R3 = 2
        ins(1, 3, 3, 0, 0, 0, "R3");          // R3 = 4
        for (int k = 0; k < 7; k++) ins(1, 2, 2, 0, 0, 0, "R10"); // R2 -> 0x80
        ins(1, 1, 0, 0, 0, 0, "R10");         // 0xFF+1 wraps, carry, zero
        ins(0, 0, 3, 1, 0, 0, "R10");         // 1-4 borrow, no write
        ins(1, 3, 0, 1, 0, 0, "R3");          // R3 = 3
        ins(1, 3, 3, 2, 0, 0, "R3");          // R3 = 9
        ins(0, 2, 3, 2, 0, 0, "R3");          // 0x80*9 low byte
        ins(0, 3, 0, 3, 0, 0, "R3");          // 9 & 1
        ins(0, 2, 0, 1, 0, 0, "R10");         // 0x80-1 signed overflow
        ins(0, 3, 3, 0, 0, 3, "R7");          // mem[9] = 9
        ins(0, 0, 1, 0, 0, 3, "R7");          // mem[0] = 1
        ins(0, 2, 0, 0, 0, 3, "R7");          // mem[1] = 0x80
        ins(1, 1, 0, 0, 0, 3, "R6");          // R1 = mem[1]
        ins(0, 3, 3, 0, 0, 0, "R6");          // observe R3
        ins(0, 3, 2, 0, 0, 3, "R8");          // out = 9, mem[0] kept
        ins(1, 3, 1, 0, 0, 3, "R8 R6");       // R3 = mem[0x80 & 7F] = 1
        ins(0, 0, 1, 0, 0, 0, "R9");
        ins(0, 1, 2, 1, 1, 1, "R11");
        ins(0, 2, 3, 2, 0, 2, "R11");
        for (int k = 0; k < 4; k++) ins(0, k, 0, 0, 0, 0, "R12");
        ins(1, 2, 0, 0, 0, 3, "R12");         // R2 = mem[1]
        ins(0, 0, 1, 0, 0, 3, "R9");          // out = 1
        ins(0, 3, 3, 1, 0, 1, "R9");
        do_reset();
        ins(1, 2, 0, 0, 0, 3, "R1");          // memory survives reset
        ins(0, 2, 0, 0, 0, 0, "R1");
        ins(0, 1, 0, 0, 0, 0, "R1");
        wait (q.size() == 0);
        #10;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule